// File: doc/BRIEF.md
# Z80 Bus Master Cycle Engine

This block lets a controller inside the chip borrow the bus of a Z80-family processor and run memory cycles on it. Once the processor has handed over its bus, the controller issues one command at a time: read one byte, write one byte, or fill a run of consecutive addresses with one value. Between commands the processor keeps running, and the bus goes back to it with a release command. Every command finishes with a one-cycle `done` strobe. The `err` flag is valid from that strobe until the next command completes.

On the bus side all strobes are active low: bus request, memory enable, read, write, non-maskable interrupt and processor reset. The engine samples the processor's bus-acknowledge line and drives a 19-bit address bus and an 8-bit data bus, each with its own output enable, so that pads outside the block can tristate them. The processor reset line has its own mode control. It can be held low, held high, or given one low pulse of a fixed number of ticks, where the tick period is chosen per command.

The acknowledge input is treated as synchronous to `clk`. All bus outputs come straight from registers.

Top module: `zbus_master`

## Requirements
- R1: After reset, `busreq_n`, `me_n`, `rd_n`, `wr_n`, `nmi_n` and `reset_n` are high, `addr_oe` and `data_oe` are low, and `ready` is high.
- R2: Acquire (`cmd_op`=1) drives `busreq_n` low. `addr_oe` rises only in the cycle after `busack_n` has been seen low. The command completes with `err`=0.
- R3: Release (`cmd_op`=2) turns off `data_oe`, then `addr_oe`, then raises `busreq_n`. `done` comes only after `busack_n` is seen high. Afterwards the bus is no longer owned.
- R4: Write (`cmd_op`=4) places the address and then lowers `me_n`. It then drives `cmd_data` with `data_oe` high, pulses `wr_n` low for one clock, and then raises `me_n`. `rd_n` stays high throughout.
- R5: Read (`cmd_op`=3) places the address, lowers `me_n` with `data_oe` low, and holds `rd_n` low for exactly two clocks. The byte on `data_in` at the end of that window appears on `rd_data` when `done` is high.
- R6: Fill (`cmd_op`=5) lowers `me_n` once and gives `cmd_len` write pulses of `cmd_data` to addresses `cmd_addr`, `cmd_addr`+1, and so on. `me_n` rises only after the last pulse. A length of 0 completes with no bus activity and `err`=0.
- R7: Reset command (`cmd_op`=6) selects a mode with `cmd_data[1:0]`: 0 holds `reset_n` low, 1 holds it high, 2 or 3 gives one low pulse of 48×P clocks, where P=`cmd_len` (0 counts as 1). For the pulse, `done` follows its end.
- R8: Release, read, write or fill issued while the bus is not owned completes at once with `err`=1 and moves no bus strobe.
- R9: `ready` is low from the cycle after a command is accepted until its completion. A `cmd_valid` seen while `ready` is low is ignored. While `ready` is high, `me_n`, `rd_n` and `wr_n` are high and `data_oe` is low.
- R10: If `busack_n` does not reach the awaited level within the acknowledge timeout, acquire or release ends with `err`=1. An aborted acquire returns `busreq_n` high with `addr_oe` low.
- R11: Opcodes 0 and 7 are reserved and complete at once with `err`=1. `nmi_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when `ready` is high |
| cmd_op | input | 3 | Command code (see R2–R11) |
| cmd_addr | input | ADDR_W | Start address for read, write or fill |
| cmd_data | input | DATA_W | Write/fill byte; reset mode in bits 1:0 |
| cmd_len | input | LEN_W | Fill length, or reset tick period |
| ready | output | 1 | Engine idle and able to take a command |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Outcome of the last completed command |
| rd_data | output | DATA_W | Byte captured by the last read |
| busreq_n | output | 1 | Bus request to the processor |
| busack_n | input | 1 | Bus acknowledge from the processor |
| me_n | output | 1 | Memory enable strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| nmi_n | output | 1 | Non-maskable interrupt, held inactive |
| reset_n | output | 1 | Processor reset line |
| addr_out | output | ADDR_W | Address bus value |
| addr_oe | output | 1 | Address bus output enable |
| data_out | output | DATA_W | Data bus value when driving |
| data_oe | output | 1 | Data bus output enable |
| data_in | input | DATA_W | Data bus value when receiving |

## Verification
The bench builds the engine with an acknowledge timeout of 20 cycles rather than the default 1000. This lets the acquire and release abort paths finish within a few dozen clocks, against a processor model whose acknowledge is either three cycles late, stuck high or stuck low. The pulse length stays at 48 ticks, and the period is driven as 0 and 2 per command. That covers both the zero-as-one rule and an exact 96-clock low window. With the 8-bit length field, fills of 0, 1, 5 and 20 bytes are reached, including one run that wraps the low address byte.

// File: rtl/zbm_pkg.sv
package zbm_pkg;

    localparam int ZB_ADDR_W      = 19;
    localparam int ZB_DATA_W      = 8;
    localparam int ZB_LEN_W       = 8;
    localparam int ZB_PULSE_TICKS = 48;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACQ  = 3'd1,
        OP_REL  = 3'd2,
        OP_RD   = 3'd3,
        OP_WR   = 3'd4,
        OP_FILL = 3'd5,
        OP_RST  = 3'd6,
        OP_RSV  = 3'd7
    } zbm_op_e;

    typedef enum logic [1:0] {
        RM_LOW   = 2'd0,
        RM_HIGH  = 2'd1,
        RM_PULSE = 2'd2,
        RM_PULS2 = 2'd3
    } zbm_rmode_e;

    typedef enum logic [4:0] {
        S_IDLE, S_ACQ_WAIT, S_REL_ADDR, S_REL_REQ, S_REL_WAIT,
        S_RD_ME, S_RD_LO, S_RD_HOLD, S_RD_SAMP,
        S_WR_ME, S_WR_DATA, S_WR_LO, S_WR_HI,
        S_FL_ADDR, S_FL_LO, S_FL_HI, S_END, S_RST_WAIT
    } zbm_state_e;

    // Registered bus control strobes, all driven from one place.
    typedef struct packed {
        logic busreq_n;
        logic me_n;
        logic rd_n;
        logic wr_n;
        logic addr_oe;
        logic data_oe;
    } zbm_ctl_t;

    localparam zbm_ctl_t CTL_IDLE = '{busreq_n: 1'b1, me_n: 1'b1, rd_n: 1'b1,
                                      wr_n: 1'b1, addr_oe: 1'b0, data_oe: 1'b0};

    function automatic logic needs_bus(zbm_op_e op);
        return (op == OP_REL) || (op == OP_RD) || (op == OP_WR) || (op == OP_FILL);
    endfunction

endpackage

// File: rtl/zbm_ack_timer.sv
module zbm_ack_timer #(
    parameter int TMO = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(TMO + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != W'(TMO)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == W'(TMO));
endmodule

// File: rtl/zbm_rstgen.sv
module zbm_rstgen
    import zbm_pkg::*;
#(
    parameter int LEN_W = ZB_LEN_W,
    parameter int TICKS = ZB_PULSE_TICKS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [LEN_W-1:0] period,
    output logic             reset_n,
    output logic             busy
);
    localparam int CNT_W = LEN_W + $clog2(TICKS + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_eff;
    logic [CNT_W-1:0] total;

    assign per_eff = (period == '0) ? CNT_W'(1) : CNT_W'(period);
    assign total   = CNT_W'(TICKS) * per_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            reset_n <= 1'b1;
            busy    <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            case (zbm_rmode_e'(mode))
                RM_LOW:  begin reset_n <= 1'b0; busy <= 1'b0; end
                RM_HIGH: begin reset_n <= 1'b1; busy <= 1'b0; end
                default: begin
                    reset_n <= 1'b0;
                    busy    <= 1'b1;
                    cnt     <= total - 1'b1;
                end
            endcase
        end else if (busy) begin
            if (cnt == '0) begin
                reset_n <= 1'b1;
                busy    <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/zbm_seq.sv
module zbm_seq
    import zbm_pkg::*;
#(
    parameter int ADDR_W = ZB_ADDR_W,
    parameter int DATA_W = ZB_DATA_W,
    parameter int LEN_W  = ZB_LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              busack_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              tmo_hit,
    input  logic              rst_busy,
    output logic              tmo_run,
    output logic              rst_start,
    output logic              ready,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output zbm_ctl_t          ctl,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out
);
    zbm_state_e        state;
    zbm_op_e           op;
    logic              owned;
    logic [LEN_W-1:0]  remain;
    logic [ADDR_W-1:0] next_addr;

    assign op        = zbm_op_e'(cmd_op);
    assign ready     = (state == S_IDLE);
    assign tmo_run   = (state == S_ACQ_WAIT) || (state == S_REL_WAIT);
    assign rst_start = ready && cmd_valid && (op == OP_RST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            ctl       <= CTL_IDLE;
            owned     <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            rd_data   <= '0;
            addr_out  <= '0;
            data_out  <= '0;
            remain    <= '0;
            next_addr <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (cmd_valid) begin
                    if (needs_bus(op) && !owned) begin
                        done <= 1'b1;
                        err  <= 1'b1;
                    end else begin
                        case (op)
                            OP_ACQ: begin
                                ctl.busreq_n <= 1'b0;
                                state        <= S_ACQ_WAIT;
                            end
                            OP_REL: begin
                                ctl.data_oe <= 1'b0;
                                state       <= S_REL_ADDR;
                            end
                            OP_RD: begin
                                addr_out <= cmd_addr;
                                state    <= S_RD_ME;
                            end
                            OP_WR: begin
                                addr_out <= cmd_addr;
                                data_out <= cmd_data;
                                state    <= S_WR_ME;
                            end
                            OP_FILL: begin
                                if (cmd_len == '0) begin
                                    done <= 1'b1;
                                    err  <= 1'b0;
                                end else begin
                                    ctl.me_n    <= 1'b0;
                                    ctl.data_oe <= 1'b1;
                                    data_out    <= cmd_data;
                                    remain      <= cmd_len;
                                    next_addr   <= cmd_addr;
                                    state       <= S_FL_ADDR;
                                end
                            end
                            OP_RST: state <= S_RST_WAIT;
                            default: begin
                                done <= 1'b1;
                                err  <= 1'b1;
                            end
                        endcase
                    end
                end
                S_ACQ_WAIT: begin
                    if (!busack_n) begin
                        ctl.addr_oe <= 1'b1;
                        owned       <= 1'b1;
                        done        <= 1'b1;
                        err         <= 1'b0;
                        state       <= S_IDLE;
                    end else if (tmo_hit) begin
                        ctl.busreq_n <= 1'b1;
                        done         <= 1'b1;
                        err          <= 1'b1;
                        state        <= S_IDLE;
                    end
                end
                S_REL_ADDR: begin
                    ctl.addr_oe <= 1'b0;
                    state       <= S_REL_REQ;
                end
                S_REL_REQ: begin
                    ctl.busreq_n <= 1'b1;
                    owned        <= 1'b0;
                    state        <= S_REL_WAIT;
                end
                S_REL_WAIT: begin
                    if (busack_n || tmo_hit) begin
                        done  <= 1'b1;
                        err   <= !busack_n;
                        state <= S_IDLE;
                    end
                end
                S_RD_ME:   begin ctl.me_n <= 1'b0; state <= S_RD_LO; end
                S_RD_LO:   begin ctl.rd_n <= 1'b0; state <= S_RD_HOLD; end
                S_RD_HOLD: state <= S_RD_SAMP;
                S_RD_SAMP: begin
                    rd_data  <= data_in;
                    ctl.rd_n <= 1'b1;
                    state    <= S_END;
                end
                S_WR_ME:   begin ctl.me_n <= 1'b0; state <= S_WR_DATA; end
                S_WR_DATA: begin ctl.data_oe <= 1'b1; state <= S_WR_LO; end
                S_WR_LO:   begin ctl.wr_n <= 1'b0; state <= S_WR_HI; end
                S_WR_HI:   begin ctl.wr_n <= 1'b1; state <= S_END; end
                S_FL_ADDR: begin addr_out <= next_addr; state <= S_FL_LO; end
                S_FL_LO:   begin ctl.wr_n <= 1'b0; state <= S_FL_HI; end
                S_FL_HI: begin
                    ctl.wr_n  <= 1'b1;
                    next_addr <= next_addr + 1'b1;
                    remain    <= remain - 1'b1;
                    state     <= (remain == LEN_W'(1)) ? S_END : S_FL_ADDR;
                end
                S_END: begin
                    ctl.me_n    <= 1'b1;
                    ctl.data_oe <= 1'b0;
                    done        <= 1'b1;
                    err         <= 1'b0;
                    state       <= S_IDLE;
                end
                S_RST_WAIT: begin
                    if (!rst_busy) begin
                        done  <= 1'b1;
                        err   <= 1'b0;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/zbus_master.sv
module zbus_master
    import zbm_pkg::*;
#(
    parameter int ADDR_W  = ZB_ADDR_W,
    parameter int DATA_W  = ZB_DATA_W,
    parameter int LEN_W   = ZB_LEN_W,
    parameter int TICKS   = ZB_PULSE_TICKS,
    parameter int ACK_TMO = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              ready,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic              busreq_n,
    input  logic              busack_n,
    output logic              me_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              nmi_n,
    output logic              reset_n,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic [DATA_W-1:0] data_in
);
    zbm_ctl_t ctl;
    logic     tmo_run, tmo_hit, rst_start, rst_busy;

    zbm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_len(cmd_len),
        .busack_n(busack_n), .data_in(data_in),
        .tmo_hit(tmo_hit), .rst_busy(rst_busy),
        .tmo_run(tmo_run), .rst_start(rst_start),
        .ready(ready), .done(done), .err(err), .rd_data(rd_data),
        .ctl(ctl), .addr_out(addr_out), .data_out(data_out)
    );

    zbm_ack_timer #(.TMO(ACK_TMO)) u_tmo (
        .clk(clk), .rst(rst), .run(tmo_run), .expired(tmo_hit)
    );

    zbm_rstgen #(.LEN_W(LEN_W), .TICKS(TICKS)) u_rst (
        .clk(clk), .rst(rst), .start(rst_start),
        .mode(cmd_data[1:0]), .period(cmd_len),
        .reset_n(reset_n), .busy(rst_busy)
    );

    assign busreq_n = ctl.busreq_n;
    assign me_n     = ctl.me_n;
    assign rd_n     = ctl.rd_n;
    assign wr_n     = ctl.wr_n;
    assign addr_oe  = ctl.addr_oe;
    assign data_oe  = ctl.data_oe;
    assign nmi_n    = 1'b1;
endmodule

// File: rtl/zbm_checks.sv
module zbm_checks (
    input logic clk,
    input logic rst,
    input logic ready,
    input logic busreq_n,
    input logic busack_n,
    input logic me_n,
    input logic rd_n,
    input logic wr_n,
    input logic addr_oe,
    input logic data_oe
);
    // R2: address drivers only come on after an observed acknowledge
    a_r2_addr_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_oe) |-> $past(!busack_n));

    // R2: address drivers never on without an active request
    a_r2_addr_needs_req: assert property (@(posedge clk) disable iff (rst)
        addr_oe |-> !busreq_n);

    // R3: data drivers already off when the address drivers turn off
    a_r3_data_off_first: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_oe) |-> (!data_oe && $past(!data_oe)));

    // R3: request withdrawn only with the address bus tristated
    a_r3_req_after_tristate: assert property (@(posedge clk) disable iff (rst)
        $rose(busreq_n) |-> !addr_oe);

    // R4: write strobe only inside an enabled, driven memory cycle
    a_r4_wr_in_me: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (!me_n && data_oe && addr_oe && rd_n));

    // R5: read strobe only inside memory enable, data bus receiving
    a_r5_rd_in_me: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> (!me_n && !data_oe));

    // R5: read strobe lasts at least two clocks
    a_r5_rd_two: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n) |=> !rd_n);

    // R9: an idle engine leaves all cycle strobes inactive
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        ready |-> (me_n && rd_n && wr_n && !data_oe));
endmodule

bind zbus_master zbm_checks u_checks (
    .clk(clk), .rst(rst), .ready(ready), .busreq_n(busreq_n),
    .busack_n(busack_n), .me_n(me_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr_oe(addr_oe), .data_oe(data_oe)
);

// File: tb/tb_zbus_master.sv
module tb_zbus_master;
    localparam int AW = 19;
    localparam int DW = 8;
    localparam int LW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          ready, done, err;
    logic [DW-1:0] rd_data;
    logic          busreq_n, busack_n, me_n, rd_n, wr_n, nmi_n, reset_n;
    logic [AW-1:0] addr_out;
    logic          addr_oe, data_oe;
    logic [DW-1:0] data_out, data_in;

    zbus_master #(.ACK_TMO(20)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_len(cmd_len),
        .ready(ready), .done(done), .err(err), .rd_data(rd_data),
        .busreq_n(busreq_n), .busack_n(busack_n), .me_n(me_n), .rd_n(rd_n),
        .wr_n(wr_n), .nmi_n(nmi_n), .reset_n(reset_n), .addr_out(addr_out),
        .addr_oe(addr_oe), .data_out(data_out), .data_oe(data_oe),
        .data_in(data_in)
    );

    // Processor model: acknowledge follows request three clocks late.
    logic       cpu_dead = 1'b0;
    logic       cpu_stuck = 1'b0;
    logic [2:0] dl;
    always_ff @(posedge clk) dl <= rst ? 3'b111 : {dl[1:0], busreq_n};
    assign busack_n = cpu_stuck ? 1'b0 : (cpu_dead ? 1'b1 : dl[2]);

    logic [7:0] busmem [256];
    logic [7:0] exp_mem [256];
    assign data_in = (!rd_n && !me_n) ? busmem[addr_out[7:0]] : 8'h00;

    // Bus monitor, sampled on the falling edge.
    int            n_wr = 0, n_mefall = 0, rd_run = 0, rd_last = 0, rst_low = 0;
    logic          p_wr = 1'b1, p_me = 1'b1;
    logic [AW-1:0] last_wa = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!p_wr && wr_n) begin
                n_wr++;
                last_wa = addr_out;
                busmem[addr_out[7:0]] = data_out;
            end
            if (p_me && !me_n) n_mefall++;
            if (!rd_n) rd_run++;
            else if (rd_run != 0) begin rd_last = rd_run; rd_run = 0; end
            if (!reset_n) rst_low++;
        end
        p_wr = wr_n;
        p_me = me_n;
    end

    int n_chk = 0, n_err = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 7 + 3);
    endfunction

    task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] a,
                           input logic [7:0] d, input logic [7:0] l, output logic e);
        int cyc;
        while (!ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_len = l;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
        chk(done, "R9 command never completed", 0, 1);
        e = err;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string tag);
        logic e;
        run_cmd(3'd3, a, 8'h00, 8'h00, e);
        chk(e == 1'b0, {tag, " read err"}, e, 0);
        chk(rd_data == exp_mem[a[7:0]], {tag, " read data"}, rd_data, exp_mem[a[7:0]]);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic e;
        int   wr0, me0;
        for (int i = 0; i < 256; i++) begin busmem[i] = pat(i); exp_mem[i] = pat(i); end
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk({busreq_n, me_n, rd_n, wr_n, nmi_n, reset_n} == 6'h3f, "R1 strobes idle",
            {busreq_n, me_n, rd_n, wr_n, nmi_n, reset_n}, 6'h3f);
        chk(!addr_oe && !data_oe, "R1 drivers off", {addr_oe, data_oe}, 0);
        chk(ready, "R1 ready", ready, 1);

        // R8 commands without ownership
        me0 = n_mefall;
        run_cmd(3'd3, 19'h00010, 8'h00, 8'h00, e);
        chk(e, "R8 read unowned err", e, 1);
        run_cmd(3'd4, 19'h00010, 8'h55, 8'h00, e);
        chk(e, "R8 write unowned err", e, 1);
        run_cmd(3'd5, 19'h00010, 8'h55, 8'h04, e);
        chk(e, "R8 fill unowned err", e, 1);
        run_cmd(3'd2, 19'h0, 8'h00, 8'h00, e);
        chk(e, "R8 release unowned err", e, 1);
        chk(n_mefall == me0 && n_wr == 0 && busreq_n, "R8 no bus activity", n_mefall - me0, 0);

        // R11 reserved codes and interrupt line
        run_cmd(3'd7, 19'h0, 8'h00, 8'h00, e);
        chk(e, "R11 reserved 7 err", e, 1);
        run_cmd(3'd0, 19'h0, 8'h00, 8'h00, e);
        chk(e && nmi_n, "R11 reserved 0 err", e, 1);

        // R2 acquire
        run_cmd(3'd1, 19'h0, 8'h00, 8'h00, e);
        chk(!e, "R2 acquire err", e, 0);
        chk(addr_oe && !busreq_n && !busack_n, "R2 owned state",
            {addr_oe, busreq_n, busack_n}, 3'b100);

        // R4 directed write, R5 directed read
        run_cmd(3'd4, 19'h75A3C, 8'hA5, 8'h00, e);
        exp_mem[8'h3C] = 8'hA5;
        chk(!e && n_wr == 1, "R4 one write pulse", n_wr, 1);
        chk(last_wa == 19'h75A3C, "R4 write address", last_wa, 19'h75A3C);
        chk(busmem[8'h3C] == 8'hA5, "R4 write data", busmem[8'h3C], 8'hA5);
        do_read(19'h75A3C, "R5 directed");
        chk(rd_last == 2, "R5 read strobe width", rd_last, 2);
        do_read(19'h00077, "R5 untouched");

        // R4/R5 random mix
        for (int k = 0; k < 40; k++) begin
            logic [AW-1:0] a;
            logic [7:0]    d;
            a = AW'($urandom);
            d = 8'($urandom);
            if ($urandom % 2 == 0) begin
                run_cmd(3'd4, a, d, 8'h00, e);
                exp_mem[a[7:0]] = d;
                chk(!e && last_wa == a, "R4 random write address", last_wa, a);
            end else begin
                do_read(a, "R5 random");
            end
        end

        // R6 fill
        wr0 = n_wr; me0 = n_mefall;
        run_cmd(3'd5, 19'h100FE, 8'h3C, 8'd5, e);
        for (int i = 0; i < 5; i++) exp_mem[8'(8'hFE + i)] = 8'h3C;
        chk(!e && n_wr - wr0 == 5, "R6 fill pulse count", n_wr - wr0, 5);
        chk(n_mefall - me0 == 1, "R6 fill one enable", n_mefall - me0, 1);
        chk(last_wa == 19'h10102, "R6 fill last address", last_wa, 19'h10102);
        for (int i = 0; i < 5; i++) do_read(19'h100FE + 19'(i), "R6 fill content");
        do_read(19'h10103, "R6 fill end untouched");
        wr0 = n_wr; me0 = n_mefall;
        run_cmd(3'd5, 19'h00020, 8'h99, 8'd0, e);
        chk(!e && n_wr == wr0 && n_mefall == me0, "R6 zero length idle", n_wr - wr0, 0);
        run_cmd(3'd5, 19'h00030, 8'h11, 8'd1, e);
        exp_mem[8'h30] = 8'h11;
        chk(n_wr - wr0 == 1, "R6 single byte fill", n_wr - wr0, 1);

        // R9 command ignored while busy
        while (!ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd5; cmd_addr = 19'h00040; cmd_data = 8'h66; cmd_len = 8'd20;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!ready, "R9 ready low while busy", ready, 0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_addr = 19'h000C0; cmd_data = 8'hEE;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        for (int i = 0; i < 20; i++) exp_mem[8'h40 + i] = 8'h66;
        do_read(19'h000C0, "R9 ignored write");
        do_read(19'h00053, "R9 fill end");

        // R3 release
        run_cmd(3'd2, 19'h0, 8'h00, 8'h00, e);
        chk(!e, "R3 release err", e, 0);
        chk(!addr_oe && !data_oe && busreq_n && busack_n, "R3 released state",
            {addr_oe, data_oe, busreq_n, busack_n}, 4'b0011);
        run_cmd(3'd3, 19'h00010, 8'h00, 8'h00, e);
        chk(e, "R3 read after release err", e, 1);

        // R10 timeouts
        run_cmd(3'd1, 19'h0, 8'h00, 8'h00, e);
        cpu_stuck = 1'b1;
        run_cmd(3'd2, 19'h0, 8'h00, 8'h00, e);
        chk(e, "R10 release timeout err", e, 1);
        chk(!addr_oe && busreq_n, "R10 release timeout state", {addr_oe, busreq_n}, 1);
        cpu_stuck = 1'b0;
        cpu_dead = 1'b1;
        run_cmd(3'd1, 19'h0, 8'h00, 8'h00, e);
        chk(e, "R10 acquire timeout err", e, 1);
        chk(busreq_n && !addr_oe, "R10 request withdrawn", {busreq_n, addr_oe}, 2'b10);
        cpu_dead = 1'b0;
        repeat (5) @(negedge clk);

        // R7 reset modes, accepted without bus ownership
        run_cmd(3'd6, 19'h0, 8'h00, 8'h00, e);
        chk(!e && !reset_n, "R7 hold low", reset_n, 0);
        run_cmd(3'd6, 19'h0, 8'h01, 8'h00, e);
        chk(!e && reset_n, "R7 hold high", reset_n, 1);
        rst_low = 0;
        run_cmd(3'd6, 19'h0, 8'h02, 8'd2, e);
        chk(!e && reset_n, "R7 pulse ends high", reset_n, 1);
        chk(rst_low == 96, "R7 pulse 48x2", rst_low, 96);
        rst_low = 0;
        run_cmd(3'd6, 19'h0, 8'h03, 8'd0, e);
        chk(rst_low == 48, "R7 pulse period zero", rst_low, 48);

        finish_run();
    end
endmodule